// File: doc/BRIEF.md
# USB Controller Common Register File

This block is the shared control area of a small USB controller that serves endpoint 0, four transmit endpoints and four receive endpoints. A processor reaches it over a byte-addressed register bus that has separate read and write strobes and a flag for 16-bit accesses. The block keeps the device address, a power/suspend control byte, transmit and receive interrupt flags with their masks, a general USB event byte with its mask, and the most recent start-of-frame number. It drives one interrupt line, which is high while any flag is set and its mask bit is also set.

Flag registers clear themselves when software reads them. A flag that arrives on the same edge as that clearing read is kept, so software sees it on the next read. An index register picks one endpoint. The window at offsets 0x10 to 0x19 is then passed through to that endpoint's control/status set, which sits outside this block. An index that names no endpoint closes the window.

Top module: `usb_common_regs`

## Requirements
- R1: After reset, reads return 0x00 at offset 0x00, 0x20 at 0x01, 0x001F at 0x06, 0x001E at 0x08, 0x06 at 0x0B and 0 at 0x02, 0x04, 0x0A, 0x0C and 0x0E.
- R2: Offset 0x00 is writable. Only its low 7 bits are stored, and bit 7 reads as 0. `dev_addr` shows the stored value while `host_mode` is 0 and shows 0 while `host_mode` is 1.
- R3: Offset 0x01 is an 8-bit read/write byte, and `power_ctrl` always shows its stored value.
- R4: A pulse on `tx_evt[n]`, for n from 0 to 4, sets bit n of the 16-bit transmit flag register at 0x02/0x03. All other bits read 0.
- R5: A pulse on `rx_evt[n]`, for n from 1 to 4, sets bit n of the receive flag register at 0x04/0x05. `rx_evt[0]` has no effect, and bit 0 reads 0.
- R6: A pulse on `usb_evt[n]` sets bit n of the 8-bit USB flag register at 0x0A.
- R7: A read that covers any byte of a flag register returns the flags held before the edge and clears that register once. An event on the same edge stays set for the next read. Writes to a flag register are ignored.
- R8: The masks at 0x06 (bits 0-4), 0x08 (bits 1-4) and 0x0B (bits 0-7) are writable. Their other bits read 0 and ignore writes.
- R9: `irq` is high exactly while some flag bit and its mask bit are both 1. It rises in the cycle after the edge that stores the event.
- R10: A pulse on `sof_valid` loads `sof_frame` into the 11-bit frame register at 0x0C/0x0D. Bits 11-15 read 0, and bus writes to it are ignored.
- R11: The index at 0x0E stores 4 bits that read back, and the upper nibble reads 0.
- R12: For an access in 0x10-0x19 with an index of 4 or less, the block drives `win_rd` or `win_wr` together with `win_ep` set to the index and `win_offs` set to the address minus 0x10, and `bus_rdata` carries `win_rdata`. With an index above 4, no strobe is driven and the read returns 0.
- R13: A 16-bit access at an even address A uses byte A on data bits 7:0 and byte A+1 on bits 15:8. A byte read returns 0 on bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_mode | input | 1 | 1 when the controller acts as host |
| bus_addr | input | 8 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wide | input | 1 | 16-bit access at an even address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of `bus_rd` |
| tx_evt | input | 5 | Transmit event pulses, endpoints 0-4 |
| rx_evt | input | 5 | Receive event pulses, bits 1-4 used |
| usb_evt | input | 8 | General USB event pulses |
| sof_valid | input | 1 | Frame number strobe |
| sof_frame | input | 11 | Received frame number |
| dev_addr | output | 7 | Device address used in peripheral mode |
| power_ctrl | output | 8 | Power/suspend control byte |
| win_ep | output | 4 | Endpoint selected by the index |
| win_offs | output | 4 | Offset within the endpoint window |
| win_rd | output | 1 | Read strobe to the endpoint set |
| win_wr | output | 1 | Write strobe to the endpoint set |
| win_wide | output | 1 | 16-bit flag passed to the endpoint set |
| win_wdata | output | 16 | Write data passed to the endpoint set |
| win_rdata | input | 16 | Read data from the endpoint set |
| irq | output | 1 | Combined masked interrupt |

## Verification
Every piece of state in this block shows at a port within one cycle:
- A flag that is lost or stuck shows on `irq` in the cycle after the event edge, and on the next status read.
- A wrong clear shows as stale or missing bits on the read that follows.
- A corrupted index shows on `win_ep` or as a strobe that should not be there, on the very next window access.
- A wrong mask bit shows as a read-back mismatch and as a wrong `irq` level.

The bench keeps a shadow of every register. It compares each read and each output against that shadow on every cycle.

// File: rtl/usb_cr_pkg.sv
// Package: offsets, reset constants and byte-lane helpers shared by the
// common register file. Assumes 16-bit accesses are even-aligned.
package usb_cr_pkg;

    localparam logic [7:0] OFF_FADDR  = 8'h00;
    localparam logic [7:0] OFF_POWER  = 8'h01;
    localparam logic [7:0] OFF_TXST   = 8'h02;
    localparam logic [7:0] OFF_RXST   = 8'h04;
    localparam logic [7:0] OFF_TXEN   = 8'h06;
    localparam logic [7:0] OFF_RXEN   = 8'h08;
    localparam logic [7:0] OFF_USBST  = 8'h0A;
    localparam logic [7:0] OFF_USBEN  = 8'h0B;
    localparam logic [7:0] OFF_FRAME  = 8'h0C;
    localparam logic [7:0] OFF_INDEX  = 8'h0E;
    localparam logic [7:0] OFF_WIN_LO = 8'h10;
    localparam logic [7:0] OFF_WIN_HI = 8'h19;

    localparam logic [7:0] POWER_RST = 8'h20;
    localparam logic [7:0] USBEN_RST = 8'h06;

    // True when the access at address a touches the byte at offset off.
    function automatic logic lane_hit(input logic [7:0] a, input logic wide,
                                      input logic [7:0] off);
        return (a == off) || (wide && ((a + 8'd1) == off));
    endfunction

    // Byte of the write data that lands on offset off.
    function automatic logic [7:0] lane_byte(input logic [7:0] a,
                                             input logic [15:0] wd,
                                             input logic [7:0] off);
        return (a == off) ? wd[7:0] : wd[15:8];
    endfunction

    // Merge a byte-lane write into a 16-bit register located at off.
    function automatic logic [15:0] merge16(input logic [15:0] old,
                                            input logic [7:0]  a,
                                            input logic        wide,
                                            input logic [15:0] wd,
                                            input logic [7:0]  off);
        logic [15:0] r;
        r = old;
        if (lane_hit(a, wide, off))
            r[7:0] = lane_byte(a, wd, off);
        if (lane_hit(a, wide, off + 8'd1))
            r[15:8] = lane_byte(a, wd, off + 8'd1);
        return r;
    endfunction

endpackage

// File: rtl/usb_cr_cor_status.sv
// Clear-on-read flag register. Event pulses set bits (only where MASK is 1).
// clr_i, one cycle wide, empties the register. An event on the same edge
// wins over the clear. Assumes clr_i comes from a decoded bus read.
module usb_cr_cor_status #(
    parameter int             W    = 5,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic         clr_i,
    output logic [W-1:0] st_o
);

    logic [W-1:0] st_q;

    // Purpose: latch events and drop old flags on a clearing read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= (clr_i ? '0 : st_q) | (evt_i & MASK);
    end

    assign st_o = st_q;

    assert_evt_latched_R4: assert property (@(posedge clk) disable iff (!rst_n)
        |(evt_i & MASK) |=> ((st_o & $past(evt_i & MASK)) == $past(evt_i & MASK)));

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && ((evt_i & MASK) == '0)) |=> (st_o == '0));

    assert_hold_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && ((evt_i & MASK) == '0)) |=> $stable(st_o));

endmodule

// File: rtl/usb_cr_ep_window.sv
// Index register plus routing of the shared endpoint window. It passes
// accesses to the selected endpoint set. An index above NUM_EP closes the
// window: no strobe goes out and reads return zero.
module usb_cr_ep_window #(
    parameter int NUM_EP = 4,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       bus_addr,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic             bus_wide,
    input  logic [15:0]      bus_wdata,
    input  logic [15:0]      win_rdata_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             hit_o,
    output logic [15:0]      rdata_o,
    output logic [IDX_W-1:0] win_ep_o,
    output logic [3:0]       win_offs_o,
    output logic             win_rd_o,
    output logic             win_wr_o,
    output logic             win_wide_o,
    output logic [15:0]      win_wdata_o
);
    import usb_cr_pkg::*;

    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_EP);

    logic [IDX_W-1:0] idx_q;
    logic             idx_wr;
    logic             in_win;
    logic             idx_ok;
    logic [7:0]       rel_addr;

    assign idx_wr = bus_wr && lane_hit(bus_addr, bus_wide, OFF_INDEX);

    // Purpose: hold the endpoint index written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx_q <= '0;
        else if (idx_wr)
            idx_q <= IDX_W'(lane_byte(bus_addr, bus_wdata, OFF_INDEX));
    end

    // Purpose: decode window hits and gate strobes on a valid index.
    always_comb begin
        in_win   = (bus_addr >= OFF_WIN_LO) && (bus_addr <= OFF_WIN_HI);
        idx_ok   = (idx_q <= IDX_MAX);
        rel_addr = bus_addr - OFF_WIN_LO;
    end

    assign idx_o       = idx_q;
    assign hit_o       = in_win;
    assign rdata_o     = (in_win && idx_ok) ? win_rdata_i : 16'h0000;
    assign win_ep_o    = idx_q;
    assign win_offs_o  = rel_addr[3:0];
    assign win_rd_o    = bus_rd && in_win && idx_ok;
    assign win_wr_o    = bus_wr && in_win && idx_ok;
    assign win_wide_o  = bus_wide;
    assign win_wdata_o = bus_wdata;

    assert_win_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd_o || win_wr_o) |-> (win_ep_o <= IDX_MAX));

    assert_idx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_wr |=> $stable(idx_o));

endmodule

// File: rtl/usb_common_regs.sv
// Common register file of a small USB controller. It decodes a byte-addressed
// bus (16-bit accesses even-aligned) and holds the address, power, mask and
// frame registers. It instantiates clear-on-read flag cells and the endpoint
// window, and forms one masked interrupt.
module usb_common_regs #(
    parameter int NUM_EP  = 4,
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_mode,
    input  logic [7:0]         bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic               bus_wide,
    input  logic [15:0]        bus_wdata,
    output logic [15:0]        bus_rdata,
    input  logic [NUM_EP:0]    tx_evt,
    input  logic [NUM_EP:0]    rx_evt,
    input  logic [7:0]         usb_evt,
    input  logic               sof_valid,
    input  logic [FRAME_W-1:0] sof_frame,
    output logic [6:0]         dev_addr,
    output logic [7:0]         power_ctrl,
    output logic [3:0]         win_ep,
    output logic [3:0]         win_offs,
    output logic               win_rd,
    output logic               win_wr,
    output logic               win_wide,
    output logic [15:0]        win_wdata,
    input  logic [15:0]        win_rdata,
    output logic               irq
);
    import usb_cr_pkg::*;

    localparam int             EPN     = NUM_EP + 1;
    localparam logic [EPN-1:0] TX_MASK = '1;
    localparam logic [EPN-1:0] RX_MASK = {{NUM_EP{1'b1}}, 1'b0};

    logic [6:0]         faddr_q;
    logic [7:0]         power_q;
    logic [EPN-1:0]     txen_q, rxen_q;
    logic [7:0]         usben_q;
    logic [FRAME_W-1:0] frame_q;
    logic [EPN-1:0]     tx_st, rx_st;
    logic [7:0]         usb_st;
    logic               tx_clr, rx_clr, usb_clr;
    logic [15:0]        txen_m, rxen_m;
    logic [3:0]         idx;
    logic               win_hit;
    logic [15:0]        win_rd_data;
    logic [7:0]         rb [16];
    logic [7:0]         hi_addr;
    logic [7:0]         reg_lo, reg_hi;

    // Purpose: a read that covers either byte of a flag register clears it.
    always_comb begin
        tx_clr  = bus_rd && (lane_hit(bus_addr, bus_wide, OFF_TXST) ||
                             lane_hit(bus_addr, bus_wide, OFF_TXST + 8'd1));
        rx_clr  = bus_rd && (lane_hit(bus_addr, bus_wide, OFF_RXST) ||
                             lane_hit(bus_addr, bus_wide, OFF_RXST + 8'd1));
        usb_clr = bus_rd && lane_hit(bus_addr, bus_wide, OFF_USBST);
    end

    usb_cr_cor_status #(.W(EPN), .MASK(TX_MASK)) u_tx_st (
        .clk(clk), .rst_n(rst_n), .evt_i(tx_evt), .clr_i(tx_clr), .st_o(tx_st));

    usb_cr_cor_status #(.W(EPN), .MASK(RX_MASK)) u_rx_st (
        .clk(clk), .rst_n(rst_n), .evt_i(rx_evt), .clr_i(rx_clr), .st_o(rx_st));

    usb_cr_cor_status #(.W(8), .MASK(8'hFF)) u_usb_st (
        .clk(clk), .rst_n(rst_n), .evt_i(usb_evt), .clr_i(usb_clr), .st_o(usb_st));

    usb_cr_ep_window #(.NUM_EP(NUM_EP), .IDX_W(4)) u_win (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata),
        .win_rdata_i(win_rdata),
        .idx_o(idx), .hit_o(win_hit), .rdata_o(win_rd_data),
        .win_ep_o(win_ep), .win_offs_o(win_offs),
        .win_rd_o(win_rd), .win_wr_o(win_wr),
        .win_wide_o(win_wide), .win_wdata_o(win_wdata));

    // Purpose: merge byte-lane writes into the 16-bit mask registers.
    always_comb begin
        txen_m = merge16(16'(txen_q), bus_addr, bus_wide, bus_wdata, OFF_TXEN);
        rxen_m = merge16(16'(rxen_q), bus_addr, bus_wide, bus_wdata, OFF_RXEN);
    end

    // Purpose: software-writable address, power and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            faddr_q <= '0;
            power_q <= POWER_RST;
            txen_q  <= TX_MASK;
            rxen_q  <= RX_MASK;
            usben_q <= USBEN_RST;
        end else if (bus_wr) begin
            if (lane_hit(bus_addr, bus_wide, OFF_FADDR))
                faddr_q <= 7'(lane_byte(bus_addr, bus_wdata, OFF_FADDR));
            if (lane_hit(bus_addr, bus_wide, OFF_POWER))
                power_q <= lane_byte(bus_addr, bus_wdata, OFF_POWER);
            if (lane_hit(bus_addr, bus_wide, OFF_USBEN))
                usben_q <= lane_byte(bus_addr, bus_wdata, OFF_USBEN);
            txen_q <= EPN'(txen_m) & TX_MASK;
            rxen_q <= EPN'(rxen_m) & RX_MASK;
        end
    end

    // Purpose: capture the frame number on each frame strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_q <= '0;
        else if (sof_valid)
            frame_q <= sof_frame;
    end

    // Purpose: lay out the 16 register bytes for the read mux.
    always_comb begin
        for (int i = 0; i < 16; i++) rb[i] = 8'h00;
        rb[0]          = {1'b0, faddr_q};
        rb[1]          = power_q;
        {rb[3], rb[2]} = 16'(tx_st);
        {rb[5], rb[4]} = 16'(rx_st);
        {rb[7], rb[6]} = 16'(txen_q);
        {rb[9], rb[8]} = 16'(rxen_q);
        rb[10]         = usb_st;
        rb[11]         = usben_q;
        {rb[13], rb[12]} = 16'(frame_q);
        rb[14]         = {4'h0, idx};
    end

    // Purpose: select the byte lanes for the read data.
    always_comb begin
        hi_addr = bus_addr + 8'd1;
        reg_lo  = (bus_addr < 8'd16) ? rb[bus_addr[3:0]] : 8'h00;
        reg_hi  = (bus_wide && (hi_addr < 8'd16)) ? rb[hi_addr[3:0]] : 8'h00;
        bus_rdata = win_hit ? win_rd_data : {reg_hi, reg_lo};
    end

    assign dev_addr   = host_mode ? 7'h00 : faddr_q;
    assign power_ctrl = power_q;
    assign irq = (|(tx_st & txen_q)) | (|(rx_st & rxen_q)) | (|(usb_st & usben_q));

    assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_st == '0) && (rx_st == '0) && (usb_st == '0)) |-> !irq);

    assert_frame_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sof_valid |=> $stable(frame_q));

    assert_host_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_mode |-> (dev_addr == 7'h00));

    assert_rx_bit0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_st[0]);

endmodule

// File: tb/sim_usb_common_regs.sv
// Bench for usb_common_regs. A shadow model is updated on each clock edge.
// Directed cases run first, then seeded random traffic.
module sim_usb_common_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_mode = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [4:0]  tx_evt = '0, rx_evt = '0;
    logic [7:0]  usb_evt = '0;
    logic        sof_valid = 1'b0;
    logic [10:0] sof_frame = '0;
    logic [6:0]  dev_addr;
    logic [7:0]  power_ctrl;
    logic [3:0]  win_ep, win_offs;
    logic        win_rd, win_wr, win_wide;
    logic [15:0] win_wdata, win_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    // Shadow state
    logic [6:0]  m_faddr;
    logic [7:0]  m_pwr, m_usbs, m_usbe;
    logic [4:0]  m_txs, m_rxs, m_txe, m_rxe;
    logic [3:0]  m_idx;
    logic [10:0] m_frame;

    always #5 clk = ~clk;

    // Endpoint sets stand-in: data tells which endpoint and offset were used.
    assign win_rdata = {win_ep, win_offs, 8'h5A};

    usb_common_regs u0 (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_evt(tx_evt), .rx_evt(rx_evt), .usb_evt(usb_evt),
        .sof_valid(sof_valid), .sof_frame(sof_frame),
        .dev_addr(dev_addr), .power_ctrl(power_ctrl),
        .win_ep(win_ep), .win_offs(win_offs), .win_rd(win_rd), .win_wr(win_wr),
        .win_wide(win_wide), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .irq(irq));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic touched(input logic [7:0] a, input logic w, input logic [7:0] b);
        return (a == b) || (w && ((a + 8'd1) == b));
    endfunction

    function automatic logic [7:0] wbyte(input logic [7:0] a, input logic [15:0] d, input logic [7:0] b);
        return (a == b) ? d[7:0] : d[15:8];
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] a);
        case (a)
            8'h00: return {1'b0, m_faddr};
            8'h01: return m_pwr;
            8'h02: return {3'b0, m_txs};
            8'h04: return {3'b0, m_rxs};
            8'h06: return {3'b0, m_txe};
            8'h08: return {3'b0, m_rxe};
            8'h0A: return m_usbs;
            8'h0B: return m_usbe;
            8'h0C: return m_frame[7:0];
            8'h0D: return {5'b0, m_frame[10:8]};
            8'h0E: return {4'b0, m_idx};
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic in_win(input logic [7:0] a);
        return (a >= 8'h10) && (a <= 8'h19);
    endfunction

    function automatic logic [15:0] exp_rdata(input logic [7:0] a, input logic w);
        if (in_win(a))
            return (m_idx <= 4'd4) ? {m_idx, 4'(a - 8'h10), 8'h5A} : 16'h0000;
        return {w ? exp_byte(a + 8'd1) : 8'h00, exp_byte(a)};
    endfunction

    task automatic model_reset();
        m_faddr = '0; m_pwr = 8'h20; m_usbs = '0; m_usbe = 8'h06;
        m_txs = '0; m_rxs = '0; m_txe = 5'h1F; m_rxe = 5'h1E;
        m_idx = '0; m_frame = '0;
    endtask

    function automatic logic exp_irq();
        return |(m_txs & m_txe) || |(m_rxs & m_rxe) || |(m_usbs & m_usbe);
    endfunction

    // One bus cycle with optional events. Outputs are checked just before
    // the rising edge, and the shadow is updated after it.
    task automatic step(input string tag, input logic rd, input logic wr,
                        input logic [7:0] a, input logic w, input logic [15:0] wd,
                        input logic [4:0] te, input logic [4:0] re, input logic [7:0] ue,
                        input logic sv, input logic [10:0] sf);
        logic [15:0] m16;
        @(negedge clk);
        chk("R9 irq", {31'b0, irq}, {31'b0, exp_irq()});
        chk("R2 dev_addr", {25'b0, dev_addr}, host_mode ? 32'h0 : {25'b0, m_faddr});
        chk("R3 power_ctrl", {24'b0, power_ctrl}, {24'b0, m_pwr});
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wide = w; bus_wdata = wd;
        tx_evt = te; rx_evt = re; usb_evt = ue; sof_valid = sv; sof_frame = sf;
        #4;
        if (rd) chk({tag, " rdata"}, {16'b0, bus_rdata}, {16'b0, exp_rdata(a, w)});
        chk("R12 win_rd", {31'b0, win_rd}, {31'b0, rd && in_win(a) && (m_idx <= 4'd4)});
        chk("R12 win_wr", {31'b0, win_wr}, {31'b0, wr && in_win(a) && (m_idx <= 4'd4)});
        if ((rd || wr) && in_win(a) && (m_idx <= 4'd4)) begin
            chk("R12 win_ep", {28'b0, win_ep}, {28'b0, m_idx});
            chk("R12 win_offs", {28'b0, win_offs}, {28'b0, 4'(a - 8'h10)});
        end
        @(posedge clk);
        if (rd && (touched(a, w, 8'h02) || touched(a, w, 8'h03))) m_txs = '0;
        if (rd && (touched(a, w, 8'h04) || touched(a, w, 8'h05))) m_rxs = '0;
        if (rd && touched(a, w, 8'h0A)) m_usbs = '0;
        if (wr) begin
            if (touched(a, w, 8'h00)) m_faddr = 7'(wbyte(a, wd, 8'h00));
            if (touched(a, w, 8'h01)) m_pwr = wbyte(a, wd, 8'h01);
            if (touched(a, w, 8'h06)) m_txe = 5'(wbyte(a, wd, 8'h06));
            if (touched(a, w, 8'h08)) begin
                m16 = {8'h00, wbyte(a, wd, 8'h08)};
                m_rxe = 5'(m16) & 5'h1E;
            end
            if (touched(a, w, 8'h0B)) m_usbe = wbyte(a, wd, 8'h0B);
            if (touched(a, w, 8'h0E)) m_idx = 4'(wbyte(a, wd, 8'h0E));
        end
        m_txs = m_txs | te;
        m_rxs = m_rxs | (re & 5'h1E);
        m_usbs = m_usbs | ue;
        if (sv) m_frame = sf;
    endtask

    task automatic rd_(input string tag, input logic [7:0] a, input logic w);
        step(tag, 1'b1, 1'b0, a, w, 16'h0, 5'h0, 5'h0, 8'h0, 1'b0, 11'h0);
    endtask

    task automatic wr_(input string tag, input logic [7:0] a, input logic w, input logic [15:0] d);
        step(tag, 1'b0, 1'b1, a, w, d, 5'h0, 5'h0, 8'h0, 1'b0, 11'h0);
    endtask

    task automatic ev_(input logic [4:0] te, input logic [4:0] re, input logic [7:0] ue);
        step("EV", 1'b0, 1'b0, 8'h00, 1'b0, 16'h0, te, re, ue, 1'b0, 11'h0);
    endtask

    logic done = 1'b0;

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd_("R1 faddr", 8'h00, 1'b0);
        rd_("R1 power", 8'h01, 1'b0);
        rd_("R1 txen", 8'h06, 1'b1);
        rd_("R1 rxen", 8'h08, 1'b1);
        rd_("R1 usbst/usben", 8'h0A, 1'b1);
        rd_("R1 frame", 8'h0C, 1'b1);
        rd_("R1 index", 8'h0E, 1'b1);
        rd_("R1 txst", 8'h02, 1'b1);

        // R2: address register, host mode masks the output
        wr_("R2", 8'h00, 1'b0, 16'h00FF);
        rd_("R2 faddr bit7", 8'h00, 1'b0);
        host_mode = 1'b1;
        rd_("R2 host", 8'h00, 1'b0);
        host_mode = 1'b0;

        // R3: power byte via wide write at 0x00 (R13 lane order)
        wr_("R3 R13", 8'h00, 1'b1, 16'h1355);
        rd_("R3 R13 wide", 8'h00, 1'b1);

        // R4 / R5 / R6 set and R7 clear
        ev_(5'h1F, 5'h1F, 8'hFF);
        rd_("R4 txst", 8'h02, 1'b1);
        rd_("R7 txst cleared", 8'h02, 1'b1);
        rd_("R5 rxst high byte clears", 8'h05, 1'b0);
        rd_("R5 R7 rxst cleared", 8'h04, 1'b1);
        rd_("R6 usbst", 8'h0A, 1'b0);

        // R7: event on the edge of the clearing read survives
        ev_(5'h0, 5'h0, 8'h01);
        step("R7 same edge", 1'b1, 1'b0, 8'h0A, 1'b0, 16'h0, 5'h0, 5'h0, 8'h80, 1'b0, 11'h0);
        rd_("R7 kept", 8'h0A, 1'b1);
        wr_("R7 ro write", 8'h02, 1'b1, 16'hFFFF);
        rd_("R7 ro read", 8'h02, 1'b1);

        // R8: masks
        wr_("R8 txen", 8'h06, 1'b1, 16'hFFE0);
        rd_("R8 txen", 8'h06, 1'b1);
        wr_("R8 rxen", 8'h08, 1'b1, 16'hFFFF);
        rd_("R8 rxen", 8'h08, 1'b1);
        wr_("R8 usben", 8'h0B, 1'b0, 16'h00F0);
        rd_("R8 usben", 8'h0A, 1'b1);

        // R9: irq follows flags and masks
        ev_(5'h01, 5'h0, 8'h0);
        wr_("R9 mask tx", 8'h06, 1'b0, 16'h0001);
        wr_("R9 unmask off", 8'h06, 1'b0, 16'h0000);
        ev_(5'h0, 5'h0, 8'h10);
        rd_("R9 clear", 8'h0A, 1'b0);

        // R10: frame number
        step("R10", 1'b0, 1'b0, 8'h00, 1'b0, 16'h0, 5'h0, 5'h0, 8'h0, 1'b1, 11'h7FF);
        rd_("R10 frame", 8'h0C, 1'b1);
        wr_("R10 ro", 8'h0C, 1'b1, 16'h0000);
        rd_("R10 frame kept", 8'h0C, 1'b1);

        // R11 / R12: index and window
        wr_("R11", 8'h0E, 1'b0, 16'h00FF);
        rd_("R11 index", 8'h0E, 1'b1);
        rd_("R12 closed", 8'h12, 1'b0);
        wr_("R12 closed wr", 8'h14, 1'b0, 16'h1234);
        wr_("R12 idx", 8'h0E, 1'b0, 16'h0003);
        rd_("R12 open", 8'h12, 1'b1);
        wr_("R12 open wr", 8'h19, 1'b0, 16'hABCD);
        wr_("R12 idx4", 8'h0E, 1'b0, 16'h0004);
        rd_("R12 idx4", 8'h10, 1'b0);

        // Random traffic (R7 R9 R12 R13)
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            logic w, r, wv;
            int unsigned op;
            a  = 8'($urandom_range(0, 27));
            w  = 1'($urandom);
            if (w) a[0] = 1'b0;
            op = $urandom_range(0, 9);
            r  = (op < 6);
            wv = (op >= 6) && (op < 9);
            if (wv && (a == 8'h00 || a == 8'h01) && $urandom_range(0, 3) != 0) wv = 1'b0;
            step("R7 rnd", r, wv, a, w, 16'($urandom),
                 5'($urandom) & {5{$urandom_range(0, 2) == 0}},
                 5'($urandom) & {5{$urandom_range(0, 2) == 0}},
                 8'($urandom) & {8{$urandom_range(0, 3) == 0}},
                 ($urandom_range(0, 7) == 0), 11'($urandom));
        end

        @(negedge clk);
        chk("R9 irq final", {31'b0, irq}, {31'b0, exp_irq()});
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule